// File: doc/BRIEF.md
# CPU I/O Port Decoder

This block sits on the bus of an 8-bit processor and watches for I/O transfers. It owns two fixed port numbers, both set by parameters. A write transfer to the output port number stores the data bus in a register whose value is always visible on dedicated pins. A read transfer to the input port number puts an external 8-bit value onto the read data, together with a drive-enable that stands in for a tri-state bus driver.

A transfer is an I/O transfer only when the I/O strobe is high and the memory strobe is low. Only the low byte of the address is compared with the port numbers, so each port answers at 256 addresses that differ in bits 15..8. A parameter selects full decoding instead, in which the upper bits must be zero. When a read is recognised, the external value is captured on that clock edge. The read data then stays fixed for the rest of the transfer, even if the external pins move.

Top module: `io_port_decoder`

## Requirements
- R1: While reset is asserted and straight after it, `port_q` is 00h, `drive_en` is 0 and `rd_data` is 00h.
- R2: A clock edge at which `io_sel`=1, `wr_stb`=1, `mem_sel`=0 and `addr[7:0]`=03h (the default output port number) loads `dbus_in` into `port_q`, which shows the new value after that edge.
- R3: With the default decoding, `addr[15:8]` takes no part in matching: a write at FF03h loads the latch and a read at 5502h drives the input port.
- R4: A write transfer to any low-byte port number other than 03h, and any read transfer, leaves `port_q` unchanged; `port_q` holds its value between writes.
- R5: When `mem_sel`=1, neither port responds: `port_q` is unchanged and `drive_en` is 0, whatever the other strobes and the address are.
- R6: A write needs both strobes: `wr_stb` without `io_sel`, or `io_sel` without `wr_stb`, does not load the latch.
- R7: In any cycle with `io_sel`=1, `rd_stb`=1, `mem_sel`=0 and `addr[7:0]`=02h (the default input port number), `drive_en` is 1. In the first such cycle, `rd_data` equals `ext_in`.
- R8: From the clock edge at which a read is recognised until the read qualification drops, `rd_data` stays equal to the `ext_in` value that was present at that edge.
- R9: In any cycle without a qualified read to 02h, including a read to 03h, `drive_en` is 0 and `rd_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_sel | input | 1 | I/O transfer strobe, active high |
| mem_sel | input | 1 | Memory transfer strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| addr | input | 16 | Address bus |
| dbus_in | input | 8 | Data bus as driven by the processor |
| ext_in | input | 8 | External input port pins |
| port_q | output | 8 | Output port register value |
| rd_data | output | 8 | Read data toward the processor |
| drive_en | output | 1 | Read data drive enable |

## Verification
Writes are applied with the port number matched and with the upper address byte both clear and set, which shows whether the upper bits are ignored. They are also applied to neighbouring port numbers, including the input port's own number, which shows the port numbers are kept apart. Strobe combinations with one of the two strobes missing, or with the memory strobe added, show that all three strobe conditions are decoded. Multi-cycle reads with `ext_in` changing every cycle show the difference between a live pass-through and a value captured at recognition. Reads at the output port number show that the two directions do not alias.

// File: rtl/iodec_pkg.sv
`timescale 1ns/1ps
package iodec_pkg;

   typedef struct packed {
      logic io;
      logic mem;
      logic rd;
      logic wr;
   } bus_strobe_t;

   typedef enum logic [1:0] {
      XFER_IDLE  = 2'b00,
      XFER_READ  = 2'b01,
      XFER_WRITE = 2'b10,
      XFER_BOTH  = 2'b11
   } xfer_kind_t;

   function automatic xfer_kind_t classify_io(input bus_strobe_t s);
      logic io_ok;
      io_ok = s.io & ~s.mem;
      return xfer_kind_t'({io_ok & s.wr, io_ok & s.rd});
   endfunction

endpackage

// File: rtl/io_addr_match.sv
`timescale 1ns/1ps
module io_addr_match #(
   parameter int          ADDR_W      = 16,
   parameter int          PORT_W      = 8,
   parameter bit          FULL_DECODE = 1'b0,
   parameter logic [7:0]  PORT_NUM    = 8'h00
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int HI_W = ADDR_W - PORT_W;

   logic [PORT_W-1:0] bit_eq;

   generate
      if (PORT_W > ADDR_W || PORT_W > 8 || PORT_W < 1) begin : g_bad_width
         $error("io_addr_match: PORT_W must lie in 1..min(8,ADDR_W)");
      end
   endgenerate

   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_bit
         assign bit_eq[i] = ~(addr[i] ^ PORT_NUM[i]);
      end
   endgenerate

   generate
      if (HI_W == 0) begin : g_no_high
         assign hit = &bit_eq;
      end else if (FULL_DECODE) begin : g_full
         assign hit = (&bit_eq) & ~(|addr[ADDR_W-1:PORT_W]);
      end else begin : g_partial
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:PORT_W];
         assign hit = &bit_eq;
      end
   endgenerate

endmodule

// File: rtl/io_out_latch.sv
`timescale 1ns/1ps
module io_out_latch #(
   parameter int                 DATA_W  = 8,
   parameter logic [DATA_W-1:0]  RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("io_out_latch: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= d;
   end

   p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

endmodule

// File: rtl/io_in_hold.sv
`timescale 1ns/1ps
module io_in_hold #(
   parameter int DATA_W   = 8,
   parameter bit HOLD_RD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [DATA_W-1:0] ext,
   output logic              drive,
   output logic [DATA_W-1:0] data
);
   assign drive = sel;

   generate
      if (HOLD_RD) begin : g_hold
         logic              active;
         logic [DATA_W-1:0] snap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               active <= 1'b0;
               snap   <= '0;
            end else begin
               if (sel && !active) snap <= ext;
               active <= sel;
            end
         end

         always_comb begin
            if (!sel)        data = '0;
            else if (active) data = snap;
            else             data = ext;
         end

         p_held_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && active) |-> $stable(data));
      end else begin : g_live
         assign data = sel ? ext : '0;
      end
   endgenerate

endmodule

// File: rtl/io_port_decoder.sv
`timescale 1ns/1ps
module io_port_decoder #(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 8,
   parameter int          PORT_W      = 8,
   parameter bit          FULL_DECODE = 1'b0,
   parameter bit          HOLD_RD     = 1'b1,
   parameter logic [7:0]  OUT_PORT    = 8'h03,
   parameter logic [7:0]  IN_PORT     = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_sel,
   input  logic              mem_sel,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dbus_in,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] port_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              drive_en
);
   import iodec_pkg::*;

   localparam logic [7:0] PORT_MASK = 8'((1 << PORT_W) - 1);

   generate
      if ((OUT_PORT & ~PORT_MASK) != 8'h00 || (IN_PORT & ~PORT_MASK) != 8'h00) begin : g_bad_port
         $error("io_port_decoder: port number does not fit in PORT_W bits");
      end
   endgenerate

   bus_strobe_t strobes;
   xfer_kind_t  kind;
   logic        out_hit, in_hit;
   logic        wr_fire, rd_fire;

   assign strobes = '{io: io_sel, mem: mem_sel, rd: rd_stb, wr: wr_stb};
   assign kind    = classify_io(strobes);

   io_addr_match #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .FULL_DECODE(FULL_DECODE), .PORT_NUM(OUT_PORT)
   ) u_out_match (
      .addr(addr), .hit(out_hit)
   );

   io_addr_match #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .FULL_DECODE(FULL_DECODE), .PORT_NUM(IN_PORT)
   ) u_in_match (
      .addr(addr), .hit(in_hit)
   );

   assign wr_fire = kind[1] & out_hit;
   assign rd_fire = kind[0] & in_hit;

   io_out_latch #(
      .DATA_W(DATA_W), .RST_VAL('0)
   ) u_latch (
      .clk(clk), .rst_n(rst_n), .load(wr_fire), .d(dbus_in), .q(port_q)
   );

   io_in_hold #(
      .DATA_W(DATA_W), .HOLD_RD(HOLD_RD)
   ) u_hold (
      .clk(clk), .rst_n(rst_n), .sel(rd_fire), .ext(ext_in),
      .drive(drive_en), .data(rd_data)
   );

   p_mem_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel |-> !drive_en);

   p_mem_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel |=> $stable(port_q));

   p_half_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_sel && wr_stb) |=> $stable(port_q));

   p_drive_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> (io_sel && rd_stb && !mem_sel));

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |-> (rd_data == '0));

endmodule

// File: tb/sim_io_port_decoder.sv
`timescale 1ns/1ps
module sim_io_port_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_sel = 1'b0, mem_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  dbus_in = '0, ext_in = '0;
   logic [7:0]  port_q, rd_data;
   logic        drive_en;

   int vectors = 0;
   int misses  = 0;

   logic [7:0] m_q = 8'h00;
   logic       m_act = 1'b0;
   logic [7:0] m_snap = 8'h00;

   always #10 clk = ~clk;

   io_port_decoder u0 (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .mem_sel(mem_sel),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr), .dbus_in(dbus_in),
      .ext_in(ext_in), .port_q(port_q), .rd_data(rd_data), .drive_en(drive_en)
   );

   task automatic step(input logic io, input logic mem, input logic rd, input logic wr,
                       input logic [15:0] a, input logic [7:0] d, input logic [7:0] x,
                       input string tag);
      logic       rd_ok, wr_ok;
      logic       e_drv;
      logic [7:0] e_rd;
      #1;
      io_sel = io; mem_sel = mem; rd_stb = rd; wr_stb = wr;
      addr = a; dbus_in = d; ext_in = x;
      @(negedge clk);
      rd_ok = io && rd && !mem && (a[7:0] == 8'h02);
      wr_ok = io && wr && !mem && (a[7:0] == 8'h03);
      e_drv = rd_ok;
      e_rd  = !rd_ok ? 8'h00 : (m_act ? m_snap : x);
      vectors++;
      if (port_q !== m_q || drive_en !== e_drv || rd_data !== e_rd) begin
         misses++;
         $display("FAIL %s: port_q=%02h drive_en=%0b rd_data=%02h expected port_q=%02h drive_en=%0b rd_data=%02h",
                  tag, port_q, drive_en, rd_data, m_q, e_drv, e_rd);
      end
      @(posedge clk);
      if (!rst_n) begin
         m_q = 8'h00; m_act = 1'b0; m_snap = 8'h00;
      end else begin
         if (wr_ok) m_q = d;
         if (rd_ok && !m_act) m_snap = x;
         m_act = rd_ok;
      end
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'hEE, tag);
   endtask

   initial begin
      // R1: outputs during and after reset
      idle("R1");
      idle("R1");
      #1 rst_n = 1'b1;
      idle("R1");

      // R2: qualified write to port 03h, then the held value
      step(1, 0, 0, 1, 16'h0003, 8'hA5, 8'h00, "R2");
      idle("R2");
      idle("R2");

      // R6: one strobe missing
      step(0, 0, 0, 1, 16'h0003, 8'h11, 8'h00, "R6");
      step(1, 0, 0, 0, 16'h0003, 8'h22, 8'h00, "R6");
      idle("R6");

      // R3: upper address byte ignored
      step(1, 0, 0, 1, 16'hFF03, 8'h3C, 8'h00, "R3");
      idle("R3");
      step(1, 0, 1, 0, 16'h5502, 8'h00, 8'h6B, "R3");
      idle("R3");

      // R4: other port numbers and reads leave the latch
      step(1, 0, 0, 1, 16'h0004, 8'h77, 8'h00, "R4");
      step(1, 0, 0, 1, 16'h0002, 8'h88, 8'h00, "R4");
      step(1, 0, 0, 1, 16'h0013, 8'h99, 8'h00, "R4");
      step(1, 0, 0, 1, 16'h0083, 8'h44, 8'h00, "R4");
      idle("R4");

      // R5: memory strobe blocks both ports
      step(1, 1, 0, 1, 16'h0003, 8'h5E, 8'h00, "R5");
      step(1, 1, 1, 0, 16'h0002, 8'h00, 8'h12, "R5");
      step(0, 1, 1, 1, 16'h0003, 8'hD0, 8'h34, "R5");
      idle("R5");

      // R7 / R8: multi-cycle read with the pins moving every cycle
      step(1, 0, 1, 0, 16'h0002, 8'h00, 8'h5A, "R7");
      step(1, 0, 1, 0, 16'h0002, 8'h00, 8'hC3, "R8");
      step(1, 0, 1, 0, 16'h0002, 8'h00, 8'h0F, "R8");
      step(1, 0, 1, 0, 16'hAA02, 8'h00, 8'hF0, "R8");
      idle("R9");
      step(1, 0, 1, 0, 16'h0002, 8'h00, 8'h81, "R7");
      step(1, 0, 1, 0, 16'h0002, 8'h00, 8'h18, "R8");
      // strobe drops for one cycle, a new read recaptures
      step(0, 0, 1, 0, 16'h0002, 8'h00, 8'h27, "R9");
      step(1, 0, 1, 0, 16'h0002, 8'h00, 8'h72, "R7");
      step(1, 0, 1, 0, 16'h0002, 8'h00, 8'h00, "R8");

      // R9: read at the output port number, and latch stays after reads
      step(1, 0, 1, 0, 16'h0003, 8'h00, 8'hBB, "R9");
      step(1, 0, 1, 0, 16'h0001, 8'h00, 8'hBB, "R9");
      idle("R4");

      // R2: another write after the reads
      step(1, 0, 0, 1, 16'h1203, 8'h00, 8'h00, "R2");
      step(1, 0, 0, 1, 16'h0003, 8'hFF, 8'h00, "R2");
      idle("R2");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      #1000000;
      misses++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule